// File: doc/BRIEF.md
# Time-Shared Multichannel Complex Mixer

This block moves ten separate channels of one wideband complex baseband stream down to zero frequency while owning only a single set of four real multipliers and a single phase adder. Input I/Q samples arrive once every ten clock cycles. Each accepted sample is turned into ten mixed outputs, one per channel, issued on consecutive cycles in ascending channel order. Each output is tagged with its channel number so that downstream per-channel filters can pick out their own stream.

Every channel has its own 24-bit phase accumulator and its own tuning word. Both live in ten-deep rotating shift registers, so in each clock slot the shared adder and multipliers see exactly one channel's state. The top ten phase bits address a sine table that stores one quarter of a wave and mirrors it for the other three quadrants. Tuning words are written into a staging bank at any time. The whole bank is copied into the rotating set only when a new input sample is accepted, so a channel never changes frequency partway through a rotation.

Top module: `tdmMixer`

## Requirements
- R1: A synchronous reset drives `outValid` low and clears every phase accumulator, staged tuning word and active tuning word. The first sample accepted after reset therefore gives, on every channel, I = round(xI·32767/32768) and Q = round(xQ·32767/32768).
- R2: Each accepted sample produces ten outputs with `outValid` high, one per clock, carrying channels 0,1,…,9 in that order. The output for channel k is registered on the (k+3)-th rising edge after the edge that accepted the sample.
- R3: Channel c mixes sample n with phase P(c,n), the 24-bit wrapping sum of the active tuning words of c over samples 0..n-1 since reset. Phase bits [23:14] form an angle index a, which stands for 2π·a/1024.
- R4: With C = round(32767·cos) and S = round(32767·sin) of that angle, the outputs are I = floor((xI·C + xQ·S + 2^14)/2^15) and Q = floor((xQ·C − xI·S + 2^14)/2^15), each within ±3 LSB. Inputs and outputs are 16-bit two's complement.
- R5: An output whose rounded value lies outside the 16-bit range is clamped to 32767 or −32768.
- R6: A tuning word written with `tuneWe` takes effect from the next accepted sample on. The sample in rotation at the time of the write still advances with the previously active word.
- R7: A tuning write whose `tuneCh` is 10 or more changes no channel's word.
- R8: `inValid` is accepted when no rotation is running or in the last slot of a rotation, which allows back-to-back samples every ten cycles. An `inValid` in any other slot of a rotation is ignored: it produces no outputs and does not replace the sample in use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, ten cycles per input sample |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample strobe |
| inI | input | 16 | Input in-phase sample, signed |
| inQ | input | 16 | Input quadrature sample, signed |
| tuneWe | input | 1 | Tuning word write strobe |
| tuneCh | input | 4 | Channel addressed by the write |
| tuneWord | input | 24 | Phase increment per input sample |
| outValid | output | 1 | Mixed output strobe |
| outCh | output | 4 | Channel of the current output |
| outI | output | 16 | Mixed in-phase output, signed |
| outQ | output | 16 | Mixed quadrature output, signed |

## Verification
The mixer is driven with the ten channels set to very different tuning words: zero, exact quarter and eighth turns, a word that wraps to a tiny negative step, and irregular values. This separates errors in phase accumulation and in quadrant folding from errors in the multiply and sum. Pure-I and pure-Q inputs expose swapped or wrongly signed cross terms. Full-scale inputs of equal and opposite sign at 45-degree phases reach the clamp. Random samples cover the general product path. Writes during a rotation, writes to channels 10 and above, strobes inside a rotation, gapped and back-to-back cadences, and a reset partway through a run tell the commit, acceptance and clearing rules apart from the arithmetic.

// File: rtl/mixPkg.sv
package mixPkg;

  // Strobes from the slot controller to the datapath.
  typedef struct packed {
    logic accept;    // sample taken, staged words committed
    logic slotEn;    // one channel slot is being processed
    logic lastSlot;  // final slot of the rotation
  } mix_ctl_t;

  localparam longint PI_Q30 = 64'sd3373259426;

  // Sine of (pi/2 * k / quarter) scaled to amp, evaluated in Q30 by a series.
  function automatic int quarterSine(input int k, input int quarter, input int amp);
    longint x;
    longint x2;
    longint term;
    longint acc;
    x    = (longint'(k) * PI_Q30) / longint'(2 * quarter);
    x2   = (x * x) >>> 30;
    term = x;
    acc  = x;
    for (int n = 1; n <= 7; n++) begin
      term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    acc = (acc * longint'(amp) + (longint'(1) <<< 29)) >>> 30;
    if (acc > longint'(amp)) acc = longint'(amp);
    if (acc < 0) acc = 0;
    return int'(acc);
  endfunction

endpackage

// File: rtl/mixSineLut.sv
module mixSineLut
  import mixPkg::*;
#(
  parameter int LUT_W  = 10,
  parameter int COEF_W = 16
) (
  input  logic [LUT_W-1:0]         angle,
  output logic signed [COEF_W-1:0] sinOut,
  output logic signed [COEF_W-1:0] cosOut
);

  localparam int IDX_W   = LUT_W - 2;
  localparam int QUARTER = 1 << IDX_W;
  localparam int AMP     = (1 << (COEF_W - 1)) - 1;

  logic signed [COEF_W-1:0] quarterTab [0:QUARTER];

  for (genvar k = 0; k <= QUARTER; k++) begin : g_tab
    localparam int VAL = quarterSine(k, QUARTER, AMP);
    assign quarterTab[k] = COEF_W'(VAL);
  end

  logic [LUT_W-1:0] cosAngle;
  assign cosAngle = angle + LUT_W'(QUARTER);

  logic [IDX_W:0] sinIdx, cosIdx;
  logic signed [COEF_W-1:0] sinMag, cosMag;

  always_comb begin
    // odd quadrants read the table mirrored
    if (angle[IDX_W]) sinIdx = (IDX_W+1)'(QUARTER) - {1'b0, angle[IDX_W-1:0]};
    else              sinIdx = {1'b0, angle[IDX_W-1:0]};
    if (cosAngle[IDX_W]) cosIdx = (IDX_W+1)'(QUARTER) - {1'b0, cosAngle[IDX_W-1:0]};
    else                 cosIdx = {1'b0, cosAngle[IDX_W-1:0]};
    sinMag = quarterTab[sinIdx];
    cosMag = quarterTab[cosIdx];
    // upper half of the circle is negative
    sinOut = angle[LUT_W-1]    ? -sinMag : sinMag;
    cosOut = cosAngle[LUT_W-1] ? -cosMag : cosMag;
  end

endmodule

// File: rtl/mixCtrl.sv
module mixCtrl
  import mixPkg::*;
#(
  parameter int NUM_CH = 10,
  parameter int CH_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  output mix_ctl_t        ctl,
  output logic [CH_W-1:0] slotCh
);

  logic            busy;
  logic [CH_W-1:0] slotCnt;
  logic            atLast;
  logic            accept;

  assign atLast = busy && (slotCnt == CH_W'(NUM_CH - 1));
  assign accept = inValid && (!busy || atLast);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      slotCnt <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      slotCnt <= '0;
    end else if (atLast) begin
      busy    <= 1'b0;
      slotCnt <= '0;
    end else if (busy) begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.accept   = accept;
    ctl.slotEn   = busy;
    ctl.lastSlot = atLast;
    slotCh       = slotCnt;
  end

endmodule

// File: rtl/mixDatapath.sv
module mixDatapath
  import mixPkg::*;
#(
  parameter int NUM_CH  = 10,
  parameter int CH_W    = 4,
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 24,
  parameter int LUT_W   = 10,
  parameter int COEF_W  = 16,
  parameter int OUT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  mix_ctl_t                 ctl,
  input  logic [CH_W-1:0]          slotCh,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     tuneWe,
  input  logic [CH_W-1:0]          tuneCh,
  input  logic [PHASE_W-1:0]       tuneWord,
  output logic                     outValid,
  output logic [CH_W-1:0]          outCh,
  output logic signed [OUT_W-1:0]  outI,
  output logic signed [OUT_W-1:0]  outQ
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int SHIFT  = COEF_W - 1;
  localparam logic signed [SUM_W-1:0] RND   = SUM_W'(1) <<< (SHIFT - 1);
  localparam logic signed [SUM_W-1:0] MAX_O = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_O = -(SUM_W'(1) <<< (OUT_W - 1));

  // ---------------- per-channel state ----------------
  logic [PHASE_W-1:0] tuneStage [NUM_CH];
  logic [PHASE_W-1:0] wordSh    [NUM_CH];
  logic [PHASE_W-1:0] phaseSh   [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int NXT = (c == NUM_CH - 1) ? 0 : c + 1;

    always_ff @(posedge clk) begin
      if (rst)                                   tuneStage[c] <= '0;
      else if (tuneWe && tuneCh == CH_W'(c))     tuneStage[c] <= tuneWord;
    end

    always_ff @(posedge clk) begin
      if (rst)             wordSh[c] <= '0;
      else if (ctl.accept) wordSh[c] <= tuneStage[c];
      else if (ctl.slotEn) wordSh[c] <= wordSh[NXT];
    end

    if (c == NUM_CH - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)             phaseSh[c] <= '0;
        else if (ctl.slotEn) phaseSh[c] <= phaseSh[0] + wordSh[0];
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)             phaseSh[c] <= '0;
        else if (ctl.slotEn) phaseSh[c] <= phaseSh[NXT];
      end
    end
  end

  // ---------------- sample hold ----------------
  logic signed [DATA_W-1:0] sampI, sampQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      sampI <= '0;
      sampQ <= '0;
    end else if (ctl.accept) begin
      sampI <= inI;
      sampQ <= inQ;
    end
  end

  // ---------------- stage 1: table lookup ----------------
  logic signed [COEF_W-1:0] sinW, cosW;

  mixSineLut #(.LUT_W(LUT_W), .COEF_W(COEF_W)) i_lut (
    .angle  (phaseSh[0][PHASE_W-1 -: LUT_W]),
    .sinOut (sinW),
    .cosOut (cosW)
  );

  logic                     v1;
  logic [CH_W-1:0]          ch1;
  logic signed [DATA_W-1:0] xI1, xQ1;
  logic signed [COEF_W-1:0] sin1, cos1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      ch1  <= '0;
      xI1  <= '0;
      xQ1  <= '0;
      sin1 <= '0;
      cos1 <= '0;
    end else begin
      v1   <= ctl.slotEn;
      ch1  <= slotCh;
      xI1  <= sampI;
      xQ1  <= sampQ;
      sin1 <= sinW;
      cos1 <= cosW;
    end
  end

  // ---------------- stage 2: four real products ----------------
  logic                     v2;
  logic [CH_W-1:0]          ch2;
  logic signed [PROD_W-1:0] pIc, pQs, pQc, pIs;

  always_ff @(posedge clk) begin
    if (rst) begin
      v2  <= 1'b0;
      ch2 <= '0;
      pIc <= '0;
      pQs <= '0;
      pQc <= '0;
      pIs <= '0;
    end else begin
      v2  <= v1;
      ch2 <= ch1;
      pIc <= xI1 * cos1;
      pQs <= xQ1 * sin1;
      pQc <= xQ1 * cos1;
      pIs <= xI1 * sin1;
    end
  end

  // ---------------- stage 3: sum, round, clamp ----------------
  function automatic logic signed [OUT_W-1:0] roundSat(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] r;
    r = (s + RND) >>> SHIFT;
    if (r > MAX_O)      return OUT_W'(MAX_O);
    else if (r < MIN_O) return OUT_W'(MIN_O);
    else                return OUT_W'(r);
  endfunction

  logic signed [SUM_W-1:0] sumI, sumQ;
  assign sumI = SUM_W'(pIc) + SUM_W'(pQs);
  assign sumQ = SUM_W'(pQc) - SUM_W'(pIs);

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outCh    <= '0;
      outI     <= '0;
      outQ     <= '0;
    end else begin
      outValid <= v2;
      outCh    <= ch2;
      outI     <= roundSat(sumI);
      outQ     <= roundSat(sumQ);
    end
  end

endmodule

// File: rtl/tdmMixer.sv
module tdmMixer
  import mixPkg::*;
#(
  parameter int NUM_CH  = 10,
  parameter int DATA_W  = 16,
  parameter int PHASE_W = 24,
  parameter int LUT_W   = 10,
  parameter int COEF_W  = 16,
  parameter int OUT_W   = 16,
  parameter int CH_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     tuneWe,
  input  logic [CH_W-1:0]          tuneCh,
  input  logic [PHASE_W-1:0]       tuneWord,
  output logic                     outValid,
  output logic [CH_W-1:0]          outCh,
  output logic signed [OUT_W-1:0]  outI,
  output logic signed [OUT_W-1:0]  outQ
);

  mix_ctl_t        ctl;
  logic [CH_W-1:0] slotCh;

  mixCtrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .ctl     (ctl),
    .slotCh  (slotCh)
  );

  mixDatapath #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .DATA_W (DATA_W),
    .PHASE_W(PHASE_W),
    .LUT_W  (LUT_W),
    .COEF_W (COEF_W),
    .OUT_W  (OUT_W)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .slotCh   (slotCh),
    .inI      (inI),
    .inQ      (inQ),
    .tuneWe   (tuneWe),
    .tuneCh   (tuneCh),
    .tuneWord (tuneWord),
    .outValid (outValid),
    .outCh    (outCh),
    .outI     (outI),
    .outQ     (outQ)
  );

endmodule

// File: rtl/mixChecker.sv
module mixChecker #(
  parameter int NUM_CH = 10,
  parameter int CH_W   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            outValid,
  input logic [CH_W-1:0] outCh,
  input logic            accept,
  input logic            slotEn,
  input logic            lastSlot
);

  localparam int GAP_W = $clog2(NUM_CH + 1);

  logic [GAP_W-1:0] sinceAcc;

  always_ff @(posedge clk) begin
    if (rst)                                sinceAcc <= GAP_W'(NUM_CH);
    else if (accept)                        sinceAcc <= '0;
    else if (sinceAcc != GAP_W'(NUM_CH))    sinceAcc <= sinceAcc + 1'b1;
  end

  // R2: channel tags climb by one inside a burst
  p_order_r2: assert property (@(posedge clk) disable iff (rst)
    outValid && outCh != CH_W'(NUM_CH - 1) |=> outValid && outCh == CH_W'($past(outCh) + 1'b1));

  // R2: after the last channel comes a gap or a new burst at channel 0
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    outValid && outCh == CH_W'(NUM_CH - 1) |=> !outValid || outCh == '0);

  // R2: a burst always opens on channel 0
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> outCh == '0);

  // R2: no tag outside the channel range
  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outCh < CH_W'(NUM_CH));

  // R8: two accepts are at least a full rotation apart
  p_gap_r8: assert property (@(posedge clk) disable iff (rst)
    accept |-> sinceAcc >= GAP_W'(NUM_CH - 1));

  // R8: an accept starts a rotation
  p_rotate_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> slotEn);

  // R8: a rotation stops after its last slot unless a new sample arrives
  p_stop_r8: assert property (@(posedge clk) disable iff (rst)
    lastSlot && !accept |=> !slotEn);

endmodule

bind tdmMixer mixChecker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_mixChecker (
  .clk      (clk),
  .rst      (rst),
  .outValid (outValid),
  .outCh    (outCh),
  .accept   (ctl.accept),
  .slotEn   (ctl.slotEn),
  .lastSlot (ctl.lastSlot)
);

// File: tb/test_tdmMixer.sv
module test_tdmMixer;

  localparam int NCH   = 10;
  localparam int PMASK = 32'h00FF_FFFF;
  localparam int TOL   = 3;
  localparam int WDOG  = 150000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               inValid = 1'b0;
  logic signed [15:0] inI = '0;
  logic signed [15:0] inQ = '0;
  logic               tuneWe = 1'b0;
  logic [3:0]         tuneCh = '0;
  logic [23:0]        tuneWord = '0;
  logic               outValid;
  logic [3:0]         outCh;
  logic signed [15:0] outI;
  logic signed [15:0] outQ;

  always #2 clk = ~clk;

  tdmMixer i_tdmMixer (
    .clk(clk), .rst(rst), .inValid(inValid), .inI(inI), .inQ(inQ),
    .tuneWe(tuneWe), .tuneCh(tuneCh), .tuneWord(tuneWord),
    .outValid(outValid), .outCh(outCh), .outI(outI), .outQ(outQ)
  );

  int checks = 0;
  int errors = 0;
  int cycleCount = 0;
  bit finished = 0;
  string curTag = "R1";

  // reference state
  int phase   [NCH];
  int pending [NCH];
  int active  [NCH];
  int accEdge = -1000;

  typedef struct {
    int due;
    int ch;
    int ei;
    int eq;
  } exp_t;
  exp_t  expQ[$];
  string tagQ[$];

  always @(posedge clk) cycleCount++;

  function automatic int clamp16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic calcExp(input int xi, input int xq, input int ph, output int ei, output int eq);
    int  a;
    real ang;
    int  c;
    int  s;
    longint si;
    longint sq;
    a   = (ph & PMASK) >> 14;
    ang = 2.0 * 3.14159265358979 * real'(a) / 1024.0;
    c   = int'(32767.0 * $cos(ang));
    s   = int'(32767.0 * $sin(ang));
    si  = longint'(xi) * c + longint'(xq) * s;
    sq  = longint'(xq) * c - longint'(xi) * s;
    ei  = clamp16((si + 16384) >>> 15);
    eq  = clamp16((sq + 16384) >>> 15);
  endtask

  task automatic modelReset();
    for (int c = 0; c < NCH; c++) begin
      phase[c] = 0; pending[c] = 0; active[c] = 0;
    end
    accEdge = -1000;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  // drive one sample strobe for one cycle; the model decides whether it is taken (R8)
  task automatic sendSample(input int xi, input int xq);
    int   edgeNo;
    exp_t e;
    edgeNo  = cycleCount + 1;
    inValid = 1'b1;
    inI     = 16'(xi);
    inQ     = 16'(xq);
    if (!rst && (edgeNo - accEdge >= NCH)) begin
      accEdge = edgeNo;
      for (int c = 0; c < NCH; c++) active[c] = pending[c];
      for (int c = 0; c < NCH; c++) begin
        e.due = edgeNo + 3 + c;
        e.ch  = c;
        calcExp(xi, xq, phase[c], e.ei, e.eq);
        expQ.push_back(e);
        tagQ.push_back(curTag);
        phase[c] = (phase[c] + active[c]) & PMASK;
      end
    end
    tick();
    inValid = 1'b0;
  endtask

  task automatic writeTune(input int ch, input int w);
    tuneWe   = 1'b1;
    tuneCh   = 4'(ch);
    tuneWord = 24'(w);
    if (ch < NCH) pending[ch] = w & PMASK;
    tick();
    tuneWe = 1'b0;
  endtask

  // every-clock comparison against the reference schedule
  always @(negedge clk) begin
    exp_t  e;
    string t;
    int    ai;
    int    aq;
    if (!finished) begin
      checks++;
      if (expQ.size() > 0 && expQ[0].due == cycleCount) begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (!outValid || int'(outCh) != e.ch) begin
          errors++;
          $display("FAIL R2: valid %0d ch %0d, expected valid 1 ch %0d", outValid, outCh, e.ch);
        end else begin
          ai = int'(outI);
          aq = int'(outQ);
          checks++;
          if (ai - e.ei > TOL || e.ei - ai > TOL || aq - e.eq > TOL || e.eq - aq > TOL) begin
            errors++;
            $display("FAIL %s: ch %0d I %0d Q %0d, expected I %0d Q %0d", t, e.ch, ai, aq, e.ei, e.eq);
          end
        end
      end else if (outValid) begin
        errors++;
        $display("FAIL %s R2: unexpected output ch %0d, expected no valid", rst ? "R1" : curTag, outCh);
      end
    end
  end

  int words [NCH] = '{32'h000000, 32'h400000, 32'h200000, 32'h800000, 32'h001234,
                      32'hFFFFFF, 32'h155555, 32'h6B0000, 32'h0C0000, 32'hF00000};

  initial begin
    modelReset();
    rst = 1'b1;
    idle(4);
    rst = 1'b0;
    tick();

    // R1: reset state, all channels at phase zero
    curTag = "R1";
    sendSample(12000, -7000);
    idle(9);
    sendSample(-20000, 31000);
    idle(12);

    // R3, R6: load distinct words while a rotation runs
    curTag = "R3";
    sendSample(1000, 0);
    for (int c = 0; c < 9; c++) writeTune(c, words[c]);
    writeTune(9, words[9]);
    sendSample(0, 1000);
    idle(9);
    for (int n = 0; n < 12; n++) begin
      sendSample((n % 2 == 0) ? 9000 : 0, (n % 3 == 0) ? -15000 : 4000);
      idle(9);
    end

    // R5: full-scale inputs against 45-degree phases
    curTag = "R5";
    for (int n = 0; n < 8; n++) begin
      sendSample((n % 2 == 0) ? 32767 : -32768, (n % 4 < 2) ? 32767 : -32768);
      idle(9);
    end

    // R6: write during a rotation, then observe the change only on the following sample
    curTag = "R6";
    sendSample(20000, 5000);
    idle(3);
    writeTune(1, 32'h123456);
    writeTune(3, 32'h000100);
    idle(4);
    for (int n = 0; n < 4; n++) begin
      sendSample(20000, 5000);
      idle(9);
    end

    // R7: writes to channels 10..15 change nothing
    curTag = "R7";
    writeTune(10, 32'hABCDEF);
    writeTune(12, 32'h111111);
    writeTune(15, 32'h7FFFFF);
    for (int n = 0; n < 4; n++) begin
      sendSample(-12000, 18000);
      idle(9);
    end

    // R8: strobe inside a rotation is dropped; also gapped cadence
    curTag = "R8";
    sendSample(15000, -15000);
    idle(3);
    sendSample(-32000, 32000);
    idle(5);
    sendSample(7000, 7000);
    idle(25);
    sendSample(3000, -9000);
    idle(8);
    sendSample(1, 2);
    idle(12);

    // R4: random samples
    curTag = "R4";
    for (int n = 0; n < 30; n++) begin
      sendSample(int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768);
      idle(9);
    end
    idle(20);

    // R1: reset in the middle of a run, after the pipeline has drained
    curTag = "R1";
    rst = 1'b1;
    modelReset();
    idle(3);
    rst = 1'b0;
    tick();
    sendSample(-25000, 11000);
    idle(9);
    sendSample(4000, 4000);
    idle(20);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: run not finished, expected end within %0d cycles", WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule